// File: doc/BRIEF.md
# Center-Aligned PWM Compare Generator

This block makes a symmetric PWM waveform. A time-base counter climbs from zero to a programmed period value and then falls back to zero. One PWM cycle is therefore twice the period value in clock cycles. For example, a period of 600 gives a 1200-clock cycle. A compare value sets the duty.

- When the counter is at zero, the output goes high.
- When the counter passes the compare value on the way up, the output goes low.
- When the counter passes the compare value on the way down, the output goes high again.

The high time is therefore centred on the counter's zero point and the low time is centred on its peak.

Software writes the compare value into a holding register. The working register takes the held value only at the counter's zero point, so a cycle never runs with a mixture of two duty values. The block also brings out three signals for downstream load or trigger logic:

- a single-cycle pulse at zero;
- a single-cycle pulse at the peak;
- a flag that gives the direction of the counter's next step.

The period input must be at least 1.

Top module: `cpwm_center_gen`

## Requirements
- R1: While `rst_n` is low, the counter is 0, `pwm_o` is 0, `zero_o` is 1, `peak_o` is 0 and `up_o` is 1. Both compare registers are cleared.
- R2: The counter steps by exactly one on every clock. Its sequence is 0, 1, …, P, P−1, …, 1, 0, where P is `period_i`, so a full cycle is 2·P clocks. The counter never holds an end value for two clocks.
- R3: `zero_o` is high for exactly one clock in each 2·P-clock cycle, the clock in which the counter is 0.
- R4: `peak_o` is high for exactly one clock per cycle, P clocks after `zero_o`, when the counter equals P.
- R5: `up_o` is 1 when the next counter step is upward and 0 when it is downward. In each cycle it is high for P clocks: at zero and on the rising side below P.
- R6: In the clock after `zero_o`, `pwm_o` is 1 if the compare value taking effect is non-zero, and 0 otherwise.
- R7: For an effective compare value C with 0 < C < P, `pwm_o` falls one clock after the upward match (counter equals C) and rises one clock after the downward match. This gives 2·C high clocks and 2·(P−C) low clocks per cycle.
- R8: A write (`cmp_wr_i` high, `cmp_data_i` holding the value) goes to the holding register only. It has no effect on `pwm_o` until the counter next reaches 0; the working register is loaded at that zero clock.
- R9: A compare value of 0 gives a steady low output. A value of P or more gives a steady high output. In both cases there are no glitch pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | W | Counter turn-around value P (at least 1) |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_data_i | input | W | Compare value to hold |
| pwm_o | output | 1 | Registered PWM output |
| zero_o | output | 1 | Single-cycle pulse while the counter is 0 |
| peak_o | output | 1 | Single-cycle pulse while the counter is at P |
| up_o | output | 1 | Direction of the next counter step, 1 meaning upward |

## Verification
The hardest case to reach from the ports is a compare write that lands in the middle of a cycle. The held value must stay invisible until the next zero point, and the only evidence is the shape of the rest of that cycle. The bench waits for the peak pulse and writes a new value there. It then counts the high clocks on the falling half, which must match the old value, and checks the full next cycle against the new value. The edge cases where the compare value is 0, equal to P, or above P are covered by table rows, each measured over a whole cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Counter events seen in the current clock
  typedef struct packed {
    logic zero;   // counter is at 0
    logic peak;   // counter is at the turn-around value
    logic up;     // next step is upward
  } cpwm_evt_t;

  // Next output level for one clock, given the events and compare match.
  // Zero point wins over a match; the zero point sets the level only when
  // the compare value taking effect is non-zero.
  function automatic logic cpwm_next_level(
    input logic at_zero,
    input logic load_nonzero,
    input logic match,
    input logic going_up,
    input logic cur
  );
    if (at_zero)    return load_nonzero;
    else if (match) return ~going_up;
    else            return cur;
  endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output cpwm_evt_t    evt_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         dir_q;
  logic         at_zero;
  logic         at_peak;
  logic         go_up;

  always_comb begin
    at_zero = (cnt_q == '0);
    at_peak = !at_zero && (cnt_q >= period_i);
    if (at_zero)      go_up = 1'b1;
    else if (at_peak) go_up = 1'b0;
    else              go_up = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= go_up ? (cnt_q + ONE) : (cnt_q - ONE);
      dir_q <= go_up;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = '{zero: at_zero, peak: at_peak, up: go_up};

endmodule

// File: rtl/cpwm_cmp_buf.sv
module cpwm_cmp_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] held_o,
  output logic [W-1:0] active_o
);

  logic [W-1:0] held_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr_i)   held_q   <= data_i;
      if (load_i) active_q <= held_q;
    end
  end

  assign held_o   = held_q;
  assign active_o = active_q;

endmodule

// File: rtl/cpwm_action.sv
module cpwm_action
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  cpwm_evt_t    evt_i,
  input  logic [W-1:0] active_i,
  input  logic [W-1:0] loading_i,
  output logic         pwm_o
);

  logic pwm_q;
  logic match_w;
  logic load_nz_w;

  always_comb begin
    match_w   = (cnt_i == active_i);
    load_nz_w = (loading_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= cpwm_next_level(evt_i.zero, load_nz_w, match_w,
                                         evt_i.up, pwm_q);
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/cpwm_center_gen.sv
module cpwm_center_gen
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_data_i,
  output logic         pwm_o,
  output logic         zero_o,
  output logic         peak_o,
  output logic         up_o
);

  logic [W-1:0] cnt_w;
  logic [W-1:0] held_w;
  logic [W-1:0] active_w;
  cpwm_evt_t    evt_w;

  cpwm_timebase #(.W(W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .cnt_o    (cnt_w),
    .evt_o    (evt_w)
  );

  cpwm_cmp_buf #(.W(W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (evt_w.zero),
    .wr_i     (cmp_wr_i),
    .data_i   (cmp_data_i),
    .held_o   (held_w),
    .active_o (active_w)
  );

  cpwm_action #(.W(W)) u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_w),
    .evt_i     (evt_w),
    .active_i  (active_w),
    .loading_i (held_w),
    .pwm_o     (pwm_o)
  );

  assign zero_o = evt_w.zero;
  assign peak_o = evt_w.peak;
  assign up_o   = evt_w.up;

endmodule

// File: rtl/cpwm_center_chk.sv
module cpwm_center_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic [W-1:0] held,
  input logic [W-1:0] active,
  input logic         zero,
  input logic         peak,
  input logic         up,
  input logic         pwm
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

  p_zero_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> !zero);

  p_peak_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    peak |=> !peak);

  p_dir_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (cnt == ONE));

  p_dir_at_peak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    peak |-> !up);

  p_set_after_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && (held != '0)) |=> pwm);

  p_hold_midcycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> $stable(active));

  p_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && (active >= period) && $stable(period)) |=> $stable(pwm));

endmodule

bind cpwm_center_gen cpwm_center_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt    (cnt_w),
  .period (period_i),
  .held   (held_w),
  .active (active_w),
  .zero   (zero_o),
  .peak   (peak_o),
  .up     (up_o),
  .pwm    (pwm_o)
);

// File: tb/test_cpwm_center_gen.sv
module test_cpwm_center_gen;

  localparam int  W      = 16;
  localparam time CLK_NS = 10;
  localparam int  NVEC   = 9;
  // {period, compare}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd10,  16'd3},  {16'd10, 16'd7},  {16'd16, 16'd1},
    {16'd16,  16'd15}, {16'd8,  16'd0},  {16'd8,  16'd8},
    {16'd8,   16'd12}, {16'd1,  16'd1},  {16'd600, 16'd20}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] period_i = 16'd10;
  logic         cmp_wr_i = 1'b0;
  logic [W-1:0] cmp_data_i = '0;
  logic         pwm_o, zero_o, peak_o, up_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  cpwm_center_gen #(.W(W)) i_cpwm_center_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_i   (period_i),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .pwm_o      (pwm_o),
    .zero_o     (zero_o),
    .peak_o     (peak_o),
    .up_o       (up_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int p);
    rst_n    = 1'b0;
    period_i = p[W-1:0];
    cmp_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm_o == 1'b0, "R1 pwm in reset", pwm_o, 0);
    check(zero_o && up_o && !peak_o, "R1 events in reset",
          {zero_o, up_o, peak_o}, 3'b110);
    rst_n = 1'b1;
  endtask

  task automatic write_cmp(input int c);
    cmp_wr_i   = 1'b1;
    cmp_data_i = c[W-1:0];
    @(negedge clk);
    cmp_wr_i   = 1'b0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!zero_o);
  endtask

  // Called at a negedge with zero_o high; observes the next 2P samples
  task automatic measure(input int p, input int c);
    int highs = 0, zeros = 0, zpos = 0, peaks = 0, ppos = 0, ups = 0;
    int exp_hi;
    bit first_pwm = 1'b0;
    for (int k = 1; k <= 2*p; k++) begin
      @(negedge clk);
      if (k == 1) first_pwm = pwm_o;
      if (pwm_o) highs++;
      if (zero_o) begin zeros++; zpos = k; end
      if (peak_o) begin peaks++; ppos = k; end
      if (up_o) ups++;
    end
    exp_hi = (c >= p) ? 2*p : 2*c;
    check(zeros == 1 && zpos == 2*p, "R2/R3 zero spacing", zpos, 2*p);
    check(peaks == 1 && ppos == p, "R4 peak position", ppos, p);
    check(ups == p, "R5 up-flag clocks", ups, p);
    check(first_pwm == (c != 0), "R6 level after zero", first_pwm, c != 0);
    if (c == 0 || c >= p)
      check(highs == exp_hi, "R9 steady level highs", highs, exp_hi);
    else
      check(highs == exp_hi, "R7 high clocks", highs, exp_hi);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      int p, c;
      p = int'(VEC[v][31:16]);
      c = int'(VEC[v][15:0]);
      do_reset(p);
      write_cmp(c);
      wait_zero();
      measure(p, c);
    end

    // R8: write at the peak must not alter the rest of the cycle
    begin
      int p = 20, highs = 0;
      bit z_end = 1'b0;
      do_reset(p);
      write_cmp(5);
      wait_zero();
      do @(negedge clk); while (!peak_o);
      cmp_wr_i   = 1'b1;
      cmp_data_i = 16'd12;
      for (int k = 1; k <= p; k++) begin
        @(negedge clk);
        if (k == 1) cmp_wr_i = 1'b0;
        if (pwm_o) highs++;
        if (k == p) z_end = zero_o;
      end
      check(highs == 5, "R8 old value kept after mid-cycle write", highs, 5);
      check(z_end, "R8 zero reached", z_end, 1);
      measure(p, 12);
    end

    // R2: a lone step out of reset goes upward
    do_reset(4);
    @(negedge clk);
    check(up_o && !zero_o, "R2 first step upward", {up_o, zero_o}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule